// File: doc/BRIEF.md
# Platform Reset Cause Classifier

This block watches every platform event that can force a reset and turns each one into a single reset-type code from 1 to 5. The code leaves the block as an output stream with a one-cycle valid strobe. The sources are:

- byte writes to a small reset control register on the I/O bus;
- a debounced reset button;
- a repeating watchdog expiry;
- loss of core power-good;
- entry into the deepest sleep state;
- a thermal trip;
- a long power-button hold;
- a CPU shutdown indication;
- three timeout pulses.

Several sources map to different codes depending on two retained control bits and on the current sleep state.

The output stream has no ready signal and cannot apply back-pressure. The consumer must take `cause_type` in the one cycle that `cause_valid` is high. If several triggers fall in the same cycle, they collapse into one strobe that carries the highest code. Each strobe follows its trigger by exactly one clock. Sleep states use a 3-bit code in which n means Sn, so 0 is S0 and 5 is S5. The power-button threshold `HOLD_CYCLES` is set in clock cycles.

Top module: `rst_cause_classifier`

## Requirements
- R1: A write to I/O address 0xCF9 whose data has bits 7:4 = 0 and bits 2:1 = 11 is a reset request. With data bit 0 = 0 and bit 3 = 0 (for example 0x06), the request yields type 1.
- R2: A request write with bit 0 = 0 and bit 3 = 1 (for example 0x0E) yields type 2.
- R3: A request write with data bit 0 (the global bit) = 1 yields type 4. Every write to 0xCF9 stores data bits 0 and 3. A write that is not a request raises no strobe. A write to any other address changes nothing.
- R4: A rising edge of `rst_button` yields type 1 when stored bit 3 is 0, and type 2 when it is 1.
- R5: Pulses of `wdt_expire` are counted. The first pulse raises no strobe. The second pulse yields type 1 and clears the count. Any strobe clears the count.
- R6: A falling edge of `core_pwr_good` yields type 4 while `sleep_state` is 0 (S0). In any other state it yields nothing.
- R7: A change of `sleep_state` to 5 (S5) from any other value yields type 3. Staying in S5 yields nothing more.
- R8: A rising edge of `thermal_trip`, a pulse on `s5_entry_tmo`, or a pulse on `fw_wdt_tmo` each yield type 5.
- R9: Holding `pwr_button` high for `HOLD_CYCLES` consecutive samples yields exactly one type 5 strobe. A shorter hold yields nothing, and a release restarts the count.
- R10: A `cpu_shutdown` pulse yields type 4 if stored bit 0 is 1. Otherwise it yields type 2 if stored bit 3 is 1, and type 1 if not.
- R11: A pulse on `host_rst_tmo` yields type 4.
- R12: `cause_valid` rises on the clock after the trigger is sampled. Triggers in the same cycle give one strobe with the highest type. `cause_type` lies in 1..5 while valid and is 0 otherwise.
- R13: After reset, there is no strobe, both stored bits are 0 and the watchdog count is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr_en | input | 1 | I/O byte write strobe |
| io_addr | input | 16 | I/O write address |
| io_wdata | input | 8 | I/O write data byte |
| rst_button | input | 1 | Debounced reset button, high while pressed |
| wdt_expire | input | 1 | Watchdog expiry pulse |
| core_pwr_good | input | 1 | Core power-good level |
| sleep_state | input | 3 | Current sleep state, n = Sn |
| thermal_trip | input | 1 | Catastrophic thermal level |
| pwr_button | input | 1 | Power button, high while pressed |
| cpu_shutdown | input | 1 | CPU shutdown cycle pulse |
| host_rst_tmo | input | 1 | Host partition reset entry timeout pulse |
| s5_entry_tmo | input | 1 | S5 entry timeout pulse |
| fw_wdt_tmo | input | 1 | Firmware watchdog timeout pulse |
| cause_valid | output | 1 | One-cycle strobe per classified reset |
| cause_type | output | 3 | Reset type 1..5, 0 when idle |

## Verification
The two stored control bits and the watchdog count are hidden state. A wrong value in any of them shows as a wrong type or a missing strobe only when a later trigger reads it: a button press, a CPU shutdown or a second watchdog expiry. The bench therefore follows every register write with those reads, over all 256 data values. The bench also exercises the edge registers and the hold counter: a stuck edge register shows as extra strobes while an input is held, and an off-by-one counter shows as a strobe after one hold length too short or too long. All of these faults surface at the port one clock after the trigger concerned.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int unsigned NUM_TYPES = 5;
  localparam int unsigned TYPE_W    = $clog2(NUM_TYPES + 1);
  typedef logic [TYPE_W-1:0] rst_type_t;

  localparam int unsigned IO_ADDR_W = 16;
  localparam int unsigned IO_DATA_W = 8;
  localparam logic [IO_ADDR_W-1:0] CTRL_IO_ADDR = 16'h0CF9;

  // Control byte bit positions (behavioural: the type decode depends on them)
  localparam int unsigned CB_GLOBAL = 0;
  localparam int unsigned CB_HARD   = 1;
  localparam int unsigned CB_GO     = 2;
  localparam int unsigned CB_FULL   = 3;

  localparam int unsigned SLP_W = 3;
  localparam logic [SLP_W-1:0] SLP_S0 = 3'd0;
  localparam logic [SLP_W-1:0] SLP_S5 = 3'd5;
endpackage

// File: rtl/rcc_ctrl_reg.sv
module rcc_ctrl_reg
  import rcc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IO_ADDR_W-1:0] addr,
  input  logic [IO_DATA_W-1:0] wdata,
  output logic                 go,
  output logic                 go_global,
  output logic                 go_full,
  output logic                 global_q,
  output logic                 full_q
);
  logic hit;
  assign hit       = wr_en && (addr == CTRL_IO_ADDR);
  assign go        = hit && (wdata[IO_DATA_W-1:CB_FULL+1] == '0)
                         && wdata[CB_GO] && wdata[CB_HARD];
  assign go_global = wdata[CB_GLOBAL];
  assign go_full   = wdata[CB_FULL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      global_q <= 1'b0;
      full_q   <= 1'b0;
    end else if (hit) begin
      global_q <= wdata[CB_GLOBAL];
      full_q   <= wdata[CB_FULL];
    end
  end
endmodule

// File: rtl/rcc_hold_timer.sv
module rcc_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 400_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic fire
);
  localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt;

  assign fire = level && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !level) cnt <= '0;
    else if (cnt != TOP)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rcc_expiry_track.sv
module rcc_expiry_track #(
  parameter int unsigned EXPIRIES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic fire,
  output logic pending
);
  localparam int unsigned CW = (EXPIRIES > 2) ? $clog2(EXPIRIES) : 1;
  localparam logic [CW-1:0] LAST = CW'(EXPIRIES - 1);

  logic [CW-1:0] cnt;

  assign fire    = expire && (cnt == LAST);
  assign pending = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr)  cnt <= '0;
    else if (fire)      cnt <= '0;
    else if (expire)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rcc_max_pick.sv
module rcc_max_pick
  import rcc_pkg::*;
#(
  parameter int unsigned N = NUM_TYPES
) (
  input  logic [N-1:0] req,
  output logic         any,
  output rst_type_t    sel
);
  assign any = |req;

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) sel = TYPE_W'(i + 1);
    end
  end
endmodule

// File: rtl/rst_cause_classifier.sv
module rst_cause_classifier
  import rcc_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES  = 400_000_000,
  parameter int unsigned WDT_EXPIRIES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 io_wr_en,
  input  logic [IO_ADDR_W-1:0] io_addr,
  input  logic [IO_DATA_W-1:0] io_wdata,
  input  logic                 rst_button,
  input  logic                 wdt_expire,
  input  logic                 core_pwr_good,
  input  logic [SLP_W-1:0]     sleep_state,
  input  logic                 thermal_trip,
  input  logic                 pwr_button,
  input  logic                 cpu_shutdown,
  input  logic                 host_rst_tmo,
  input  logic                 s5_entry_tmo,
  input  logic                 fw_wdt_tmo,
  output logic                 cause_valid,
  output rst_type_t            cause_type
);
  logic go, go_global, go_full, global_q, full_q;
  logic hold_fire, wdt_fire, wdt_pending;
  logic btn_prev, therm_prev, pg_prev;
  logic [SLP_W-1:0] slp_prev;
  logic btn_rise, therm_rise, pg_fall_s0, s5_enter;
  logic [NUM_TYPES-1:0] req_vec;
  logic any_req;
  rst_type_t pick;

  rcc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(io_wr_en), .addr(io_addr), .wdata(io_wdata),
    .go(go), .go_global(go_global), .go_full(go_full),
    .global_q(global_q), .full_q(full_q)
  );

  rcc_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .level(pwr_button), .fire(hold_fire)
  );

  rcc_expiry_track #(.EXPIRIES(WDT_EXPIRIES)) u_wdt (
    .clk(clk), .rst_n(rst_n), .expire(wdt_expire), .clr(cause_valid),
    .fire(wdt_fire), .pending(wdt_pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      btn_prev   <= 1'b0;
      therm_prev <= 1'b0;
      pg_prev    <= 1'b0;
      slp_prev   <= SLP_S0;
    end else begin
      btn_prev   <= rst_button;
      therm_prev <= thermal_trip;
      pg_prev    <= core_pwr_good;
      slp_prev   <= sleep_state;
    end
  end

  assign btn_rise   = rst_button && !btn_prev;
  assign therm_rise = thermal_trip && !therm_prev;
  assign pg_fall_s0 = pg_prev && !core_pwr_good && (sleep_state == SLP_S0);
  assign s5_enter   = (sleep_state == SLP_S5) && (slp_prev != SLP_S5);

  // req_vec[k] requests reset type k+1
  assign req_vec[0] = (go && !go_global && !go_full)
                    | (btn_rise && !full_q)
                    | wdt_fire
                    | (cpu_shutdown && !global_q && !full_q);
  assign req_vec[1] = (go && !go_global && go_full)
                    | (btn_rise && full_q)
                    | (cpu_shutdown && !global_q && full_q);
  assign req_vec[2] = s5_enter;
  assign req_vec[3] = (go && go_global)
                    | (cpu_shutdown && global_q)
                    | pg_fall_s0
                    | host_rst_tmo;
  assign req_vec[4] = therm_rise | s5_entry_tmo | fw_wdt_tmo | hold_fire;

  rcc_max_pick #(.N(NUM_TYPES)) u_pick (
    .req(req_vec), .any(any_req), .sel(pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_valid <= 1'b0;
      cause_type  <= '0;
    end else begin
      cause_valid <= any_req;
      cause_type  <= any_req ? pick : '0;
    end
  end
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 io_wr_en,
  input logic [IO_ADDR_W-1:0] io_addr,
  input logic [IO_DATA_W-1:0] io_wdata,
  input logic                 core_pwr_good,
  input logic                 pg_prev,
  input logic [SLP_W-1:0]     sleep_state,
  input logic                 fw_wdt_tmo,
  input logic                 s5_entry_tmo,
  input logic                 wdt_pending,
  input logic                 cause_valid,
  input rst_type_t            cause_type
);
  a_r12_type_range: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |-> (cause_type >= 3'd1 && cause_type <= 3'd5));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_valid |-> (cause_type == 3'd0));

  a_r3_global_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_en && io_addr == CTRL_IO_ADDR && io_wdata[7:4] == 4'h0 &&
     io_wdata[2:1] == 2'b11 && io_wdata[0])
    |=> (cause_valid && cause_type >= 3'd4));

  a_r6_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_prev && !core_pwr_good && sleep_state == SLP_S0)
    |=> (cause_valid && cause_type >= 3'd4));

  a_r8_fatal_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_wdt_tmo || s5_entry_tmo) |=> (cause_valid && cause_type == 3'd5));

  a_r5_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    cause_valid |=> !wdt_pending);
endmodule

bind rst_cause_classifier rcc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
  .io_wdata(io_wdata), .core_pwr_good(core_pwr_good), .pg_prev(pg_prev),
  .sleep_state(sleep_state), .fw_wdt_tmo(fw_wdt_tmo),
  .s5_entry_tmo(s5_entry_tmo), .wdt_pending(wdt_pending),
  .cause_valid(cause_valid), .cause_type(cause_type)
);

// File: tb/rst_cause_classifier_tb.sv
module rst_cause_classifier_tb;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr_en = 1'b0;
  logic [15:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic rst_button = 1'b0, wdt_expire = 1'b0, core_pwr_good = 1'b1;
  logic [2:0] sleep_state = 3'd0;
  logic thermal_trip = 1'b0, pwr_button = 1'b0, cpu_shutdown = 1'b0;
  logic host_rst_tmo = 1'b0, s5_entry_tmo = 1'b0, fw_wdt_tmo = 1'b0;
  logic cause_valid;
  logic [2:0] cause_type;

  int n_cmp = 0, n_bad = 0, n_strobe = 0, last_type = 0, cyc = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rst_cause_classifier #(.HOLD_CYCLES(HOLD), .WDT_EXPIRIES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_addr(io_addr),
    .io_wdata(io_wdata), .rst_button(rst_button), .wdt_expire(wdt_expire),
    .core_pwr_good(core_pwr_good), .sleep_state(sleep_state),
    .thermal_trip(thermal_trip), .pwr_button(pwr_button),
    .cpu_shutdown(cpu_shutdown), .host_rst_tmo(host_rst_tmo),
    .s5_entry_tmo(s5_entry_tmo), .fw_wdt_tmo(fw_wdt_tmo),
    .cause_valid(cause_valid), .cause_type(cause_type)
  );

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && cause_valid) begin
      n_strobe  = n_strobe + 1;
      last_type = cause_type;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic mon_clear();
    n_strobe = 0;
    last_type = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    io_wr_en = 1'b1; io_addr = a; io_wdata = d;
    tick();
    io_wr_en = 1'b0;
  endtask

  task automatic expect_events(input string req, input int n, input int t);
    chk(req, n_strobe, n);
    if (n > 0) chk(req, last_type, t);
  endtask

  initial begin
    tick();
    chk("R13", int'(cause_valid), 0);
    chk("R13", int'(cause_type), 0);
    idle(3);
    rst_n = 1'b1;
    tick();
    chk("R13", int'(cause_valid), 0);
    // R13: stored bits clear -> button gives type 1
    mon_clear(); rst_button = 1'b1; tick(); rst_button = 1'b0; idle(3);
    expect_events("R13", 1, 1);
    // R13: empty watchdog count -> first expiry silent
    mon_clear(); wdt_expire = 1'b1; tick(); wdt_expire = 1'b0; idle(3);
    expect_events("R13", 0, 0);
    mon_clear(); host_rst_tmo = 1'b1; tick(); host_rst_tmo = 1'b0; idle(3);
    expect_events("R11", 1, 4);

    // R1 R2 R3 R4 R10: sweep every data byte at the control address
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      int et;
      bit go;
      b  = 8'(v);
      go = (b[7:4] == 4'h0) && b[2] && b[1];
      et = b[0] ? 4 : (b[3] ? 2 : 1);
      mon_clear(); io_write(16'h0CF9, b);
      chk("R12", int'(cause_valid), int'(go));
      idle(3);
      if (b[0]) expect_events("R3", go ? 1 : 0, 4);
      else if (b[3]) expect_events("R2", go ? 1 : 0, 2);
      else expect_events("R1", go ? 1 : 0, 1);
      mon_clear(); rst_button = 1'b1; tick(); rst_button = 1'b0; idle(3);
      expect_events("R4", 1, b[3] ? 2 : 1);
      mon_clear(); cpu_shutdown = 1'b1; tick(); cpu_shutdown = 1'b0; idle(3);
      expect_events("R10", 1, et);
    end
    // R3: other address ignored (stored bit 3 still 1 from 0xFF)
    mon_clear(); io_write(16'h0CF8, 8'h06); idle(3);
    expect_events("R3", 0, 0);
    mon_clear(); rst_button = 1'b1; tick(); rst_button = 1'b0; idle(3);
    expect_events("R3", 1, 2);

    // R12: simultaneous trigger sweep, highest type wins
    for (int m = 0; m < 32; m++) begin
      int et;
      io_write(16'h0CF9, 8'h00); idle(2);
      mon_clear();
      et = 0;
      if (m[1]) begin rst_button = 1'b1; et = 1; end
      if (m[0]) begin io_wr_en = 1'b1; io_addr = 16'h0CF9; io_wdata = 8'h0E; et = 2; end
      if (m[2]) begin sleep_state = 3'd5; et = 3; end
      if (m[3]) begin host_rst_tmo = 1'b1; et = 4; end
      if (m[4]) begin fw_wdt_tmo = 1'b1; et = 5; end
      tick();
      io_wr_en = 1'b0; rst_button = 1'b0; host_rst_tmo = 1'b0; fw_wdt_tmo = 1'b0;
      chk("R12", int'(cause_valid), (m != 0) ? 1 : 0);
      chk("R12", int'(cause_type), et);
      idle(3);
      sleep_state = 3'd0;
      idle(2);
      expect_events("R12", (m != 0) ? 1 : 0, et);
    end

    // R5: watchdog counting
    io_write(16'h0CF9, 8'h00); idle(2);
    mon_clear(); wdt_expire = 1'b1; tick(); wdt_expire = 1'b0; idle(3);
    expect_events("R5", 0, 0);
    mon_clear(); wdt_expire = 1'b1; tick(); wdt_expire = 1'b0; idle(3);
    expect_events("R5", 1, 1);
    mon_clear(); wdt_expire = 1'b1; tick(); wdt_expire = 1'b0; idle(3);
    expect_events("R5", 0, 0);
    mon_clear(); s5_entry_tmo = 1'b1; tick(); s5_entry_tmo = 1'b0; idle(3);
    expect_events("R8", 1, 5);
    mon_clear(); wdt_expire = 1'b1; tick(); wdt_expire = 1'b0; idle(3);
    expect_events("R5", 0, 0);
    mon_clear(); wdt_expire = 1'b1; tick(); wdt_expire = 1'b0; idle(3);
    expect_events("R5", 1, 1);

    // R6: power loss only in S0
    for (int s = 0; s < 5; s++) begin
      sleep_state = 3'(s); idle(2);
      mon_clear(); core_pwr_good = 1'b0; idle(4);
      expect_events("R6", (s == 0) ? 1 : 0, 4);
      core_pwr_good = 1'b1; idle(2);
    end
    sleep_state = 3'd0; idle(2);

    // R7: S5 entry
    mon_clear(); sleep_state = 3'd5; idle(6);
    expect_events("R7", 1, 3);
    mon_clear(); sleep_state = 3'd3; idle(3);
    expect_events("R7", 0, 0);
    mon_clear(); sleep_state = 3'd5; idle(3);
    expect_events("R7", 1, 3);
    sleep_state = 3'd0; idle(2);

    // R8: thermal held gives one strobe
    mon_clear(); thermal_trip = 1'b1; idle(6); thermal_trip = 1'b0; idle(2);
    expect_events("R8", 1, 5);
    mon_clear(); fw_wdt_tmo = 1'b1; tick(); fw_wdt_tmo = 1'b0; idle(3);
    expect_events("R8", 1, 5);

    // R9: hold length sweep
    for (int h = 1; h <= HOLD + 4; h++) begin
      mon_clear(); pwr_button = 1'b1; idle(h); pwr_button = 1'b0; idle(3);
      expect_events("R9", (h >= HOLD) ? 1 : 0, 5);
    end
    mon_clear();
    pwr_button = 1'b1; idle(HOLD - 1); pwr_button = 1'b0; tick();
    pwr_button = 1'b1; idle(HOLD - 1); pwr_button = 1'b0; idle(3);
    expect_events("R9", 0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= 200000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule